// File: doc/BRIEF.md
# Watchdog Timer with Lock-After-First-Write Configuration

This block is a watchdog counter that software must service before it runs out. It counts single-cycle enable ticks from one of two sources: an on-chip ring-oscillator tick or a crystal tick. Software picks the source and one of eight timeout lengths through a byte-wide configuration register. That register accepts exactly one write after reset and is frozen after that. Software restarts the count by writing a fixed key byte to a separate service register.

The block raises a reset request toward the chip's reset controller in three cases: the count expires, software writes a wrong key, or software tries to write the configuration a second time. A static configuration input can pin the count to the ring-oscillator source, so that a write cannot stop the watchdog. Access uses a simple register bus with a 16-bit address, a write strobe, write data and combinational read data.

Top module: `wdt_core`

## Requirements
- R1: After reset, a read of address FF98H returns 67H. Bits 4..3 read 00 (ring source) and bits 2..0 read 111 (longest timeout).
- R2: The first write to FF98H after reset stores write data bits 4..0. Reads of FF98H always return bit 7 as 0 and bits 6..5 as 11, whatever value was written. The contents never change again until reset.
- R3: Any later write to FF98H raises the reset request in the next cycle and leaves the register contents unchanged.
- R4: Source select bits 4..3 work as follows: 00 selects the ring tick, 01 selects the crystal tick, and 1x stops the count. While stopped, no timeout request is ever produced.
- R5: With the ring source, the request fires on the 2^(RING_BASE+s)-th ring tick, where s is bits 2..0. Crystal ticks are ignored.
- R6: With the crystal source, the request fires on the 2^(XTAL_BASE+s)-th crystal tick. Ring ticks are ignored.
- R7: On a timeout, wdt_rst_req is high for one cycle, in the cycle after the terminal tick, and the count restarts from zero.
- R8: While ring_lock is high, the block counts ring ticks whatever the select bits hold. An accepted write stores 00 in bits 4..3, so those bits read back as 00.
- R9: Writing ACH to address FF99H restarts the count from zero. An accepted configuration write also restarts it. A restart wins over a tick in the same cycle.
- R10: Writing any value other than ACH to FF99H raises the reset request in the next cycle.
- R11: Writes to any other address have no effect, and reads of any address other than FF98H return 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_lock | input | 1 | Static option: forces the ring source and disables the stop selection |
| tick_ring | input | 1 | Single-cycle ring-oscillator count enable |
| tick_xtal | input | 1 | Single-cycle crystal count enable |
| bus_addr | input | 16 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| wdt_rst_req | output | 1 | Registered reset request pulse |

## Verification
The timeout path is exercised with both tick sources active at once, at different rates and with different select codes. This makes the pulse count after a fixed number of cycles differ depending on whether the ring taps, the crystal taps or neither were followed. A stopped selection with both ticks running separates the stop code from a long timeout. The same stop-style write made under ring_lock shows that the lock overrides it. Periodic key writes placed just short of the terminal count show that a service restarts the count rather than only delaying it. Wrong keys, second configuration writes and writes to unrelated addresses separate a legitimate access from a violation.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    SRC_RING = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_STOP = 2'd2
  } wdt_src_e;

  localparam logic [4:0] MODE_RESET = 5'b00111;
  localparam logic [7:0] SERVICE_KEY = 8'hAC;
  localparam logic [2:0] READ_TOP_BITS = 3'b011;

  // Source decode: bit 4 stops, bit 3 picks the crystal; the lock forces ring.
  function automatic wdt_src_e decode_src(input logic [1:0] sel_bits, input logic force_ring);
    if (force_ring)       return SRC_RING;
    else if (sel_bits[1]) return SRC_STOP;
    else if (sel_bits[0]) return SRC_XTAL;
    else                  return SRC_RING;
  endfunction

  // Last count value before a timeout of 2^expo ticks.
  function automatic logic [31:0] terminal_count(input logic [5:0] expo);
    return (32'd1 << expo) - 32'd1;
  endfunction

endpackage

// File: rtl/wdt_modereg.sv
module wdt_modereg
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_mode,
  input  logic [4:0] wdata,
  input  logic       force_ring,
  output logic [4:0] mode_q,
  output logic       accept,
  output logic       violate
);

  logic locked_q;

  assign accept  = wr_mode & ~locked_q;
  assign violate = wr_mode & locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RESET;
      locked_q <= 1'b0;
    end else if (accept) begin
      mode_q   <= {(force_ring ? 2'b00 : wdata[4:3]), wdata[2:0]};
      locked_q <= 1'b1;
    end
  end

  assert_write_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(mode_q));

  assert_force_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && force_ring) |=> (mode_q[4:3] == 2'b00));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clr,
  input  logic [5:0] expo,
  output logic       ovf
);

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      term;
  logic [31:0]      cnt_ext;

  assign term    = wdt_pkg::terminal_count(expo);
  assign cnt_ext = 32'(cnt_q);
  assign ovf     = tick & ~clr & (cnt_ext == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (ovf)   cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == '0));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int          RING_BASE = 11,
  parameter int          XTAL_BASE = 13,
  parameter logic [15:0] MODE_ADDR = 16'hFF98,
  parameter logic [15:0] KEY_ADDR  = 16'hFF99
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ring_lock,
  input  logic        tick_ring,
  input  logic        tick_xtal,
  input  logic [15:0] bus_addr,
  input  logic        bus_we,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        wdt_rst_req
);

  localparam int MAX_BASE = (XTAL_BASE > RING_BASE) ? XTAL_BASE : RING_BASE;
  localparam int CNT_W    = MAX_BASE + 7;

  logic [4:0] mode_q;
  logic       wr_mode, wr_key;
  logic       mode_accept, mode_violate;
  logic       key_good, key_bad;
  wdt_src_e   src;
  logic       tick_sel;
  logic [5:0] expo;
  logic       ovf;
  logic       req_d;

  assign wr_mode  = bus_we & (bus_addr == MODE_ADDR);
  assign wr_key   = bus_we & (bus_addr == KEY_ADDR);
  assign key_good = wr_key & (bus_wdata == SERVICE_KEY);
  assign key_bad  = wr_key & (bus_wdata != SERVICE_KEY);

  wdt_modereg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_mode    (wr_mode),
    .wdata      (bus_wdata[4:0]),
    .force_ring (ring_lock),
    .mode_q     (mode_q),
    .accept     (mode_accept),
    .violate    (mode_violate)
  );

  assign src      = decode_src(mode_q[4:3], ring_lock);
  assign tick_sel = ((src == SRC_RING) & tick_ring) | ((src == SRC_XTAL) & tick_xtal);
  assign expo     = ((src == SRC_XTAL) ? 6'(XTAL_BASE) : 6'(RING_BASE)) + {3'b000, mode_q[2:0]};

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_sel),
    .clr   (mode_accept | key_good),
    .expo  (expo),
    .ovf   (ovf)
  );

  assign req_d = ovf | mode_violate | key_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_rst_req <= 1'b0;
    else        wdt_rst_req <= req_d;
  end

  assign bus_rdata = (bus_addr == MODE_ADDR) ? {READ_TOP_BITS, mode_q} : 8'h00;

  assert_timeout_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> wdt_rst_req);

  assert_second_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_violate |=> wdt_rst_req);

  assert_bad_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
    key_bad |=> wdt_rst_req);

  assert_no_stop_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_STOP) |-> !ovf);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !ovf) |=> !wdt_rst_req);

endmodule

// File: tb/wdt_core_tb_top.sv
module wdt_core_tb_top;

  localparam int RB = 3;
  localparam int XB = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ring_lock = 1'b0;
  logic        tick_ring = 1'b0;
  logic        tick_xtal = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        wdt_rst_req;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit finished = 0;

  int m_mode, m_cnt, m_locked, m_req;

  always #2.5 clk = ~clk;

  wdt_core #(.RING_BASE(RB), .XTAL_BASE(XB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ring_lock(ring_lock),
    .tick_ring(tick_ring), .tick_xtal(tick_xtal),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expect_read(input logic [15:0] a);
    return (a == 16'hFF98) ? (96 + m_mode) : 0;
  endfunction

  // Behavioural model of one clock, from the requirements.
  task automatic model_step(input logic [15:0] a, input bit we, input int d, input bit tr, input bit tx);
    int src; int expo; bit tk; bit clr; int req;
    req = 0; clr = 0;
    if (ring_lock || (m_mode / 8) == 0) src = 0;
    else if ((m_mode / 8) == 1) src = 1;
    else src = 2;
    expo = ((src == 1) ? XB : RB) + (m_mode % 8);
    tk = (src == 0) ? tr : ((src == 1) ? tx : 1'b0);
    if (we && a == 16'hFF98) begin
      if (m_locked == 0) begin
        m_mode = ring_lock ? (d % 8) : (d % 32);
        m_locked = 1; clr = 1;
      end else req = 1;
    end else if (we && a == 16'hFF99) begin
      if (d == 'hAC) clr = 1; else req = 1;
    end
    if (clr) m_cnt = 0;
    else if (tk) begin
      m_cnt++;
      if (m_cnt == (1 << expo)) begin req = 1; m_cnt = 0; end
    end
    m_req = req;
  endtask

  task automatic cyc(input logic [15:0] a, input bit we, input int d, input bit tr, input bit tx);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = 8'(d); tick_ring = tr; tick_xtal = tx;
    model_step(a, we, d, tr, tx);
    @(posedge clk); #1;
    check("R7 R3 R10 request", int'(wdt_rst_req), m_req);
    check("R2 R11 read", int'(bus_rdata), expect_read(a));
    if (wdt_rst_req) pulses++;
  endtask

  task automatic do_reset(input bit lock);
    @(negedge clk);
    rst_n = 0; ring_lock = lock; bus_we = 0; tick_ring = 0; tick_xtal = 0; bus_addr = 16'hFF98;
    m_mode = 7; m_cnt = 0; m_locked = 0; m_req = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset read", int'(bus_rdata), 'h67);
    check("R1 reset request", int'(wdt_rst_req), 0);
  endtask

  initial begin
    // R1 R5: default ring, code 7 -> 2^(RB+7) ticks
    do_reset(0);
    pulses = 0;
    for (int i = 0; i < 1030; i++) cyc(16'hFF98, 0, 0, 1, 1);
    check("R5 default timeout count", pulses, 1);

    // R2 R5 R7 R3: ring code 0, top bits of write ignored
    do_reset(0);
    cyc(16'hFF98, 1, 'hE0, 0, 0);
    check("R2 masked readback", int'(bus_rdata), 'h60);
    pulses = 0;
    for (int i = 0; i < 40; i++) cyc(16'hFF98, 0, 0, 1, 1);
    check("R5 R7 ring code0 pulses", pulses, 5);
    pulses = 0;
    cyc(16'hFF98, 1, 'h0F, 0, 0);
    check("R3 second write request", pulses, 1);
    check("R2 contents kept", int'(bus_rdata), 'h60);

    // R6: crystal code 2 -> 2^(XB+2)=128 crystal ticks
    do_reset(0);
    cyc(16'hFF98, 1, 'h0A, 0, 0);
    pulses = 0;
    for (int i = 0; i < 300; i++) cyc(16'hFF98, 0, 0, 1, i % 2);
    check("R6 crystal pulses", pulses, 1);

    // R4: stopped
    do_reset(0);
    cyc(16'hFF98, 1, 'h10, 0, 0);
    check("R4 stop readback", int'(bus_rdata), 'h70);
    pulses = 0;
    for (int i = 0; i < 2000; i++) cyc(16'hFF98, 0, 0, 1, 1);
    check("R4 stopped no pulse", pulses, 0);

    // R8: ring forced, stop write overridden, code 2 -> 32 ring ticks
    do_reset(1);
    cyc(16'hFF98, 1, 'h12, 0, 0);
    check("R8 forced readback", int'(bus_rdata), 'h62);
    pulses = 0;
    for (int i = 0; i < 100; i++) cyc(16'hFF98, 0, 0, 1, 1);
    check("R8 forced ring pulses", pulses, 3);

    // R9 R10 R11: service keeps it quiet
    do_reset(0);
    cyc(16'hFF98, 1, 'h01, 0, 0);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < 14; i++) cyc(16'hFF98, 0, 0, 1, 0);
      cyc(16'hFF99, 1, 'hAC, 1, 0);
    end
    check("R9 serviced no pulse", pulses, 0);
    cyc(16'hFF99, 1, 'h55, 0, 0);
    check("R10 wrong key pulse", pulses, 1);
    cyc(16'hFF00, 1, 'h00, 0, 0);
    check("R11 other address no pulse", pulses, 1);
    check("R11 other address read", int'(bus_rdata), 0);
    cyc(16'hFF98, 0, 0, 0, 0);
    check("R11 mode unchanged", int'(bus_rdata), 'h61);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 200000; n++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule